// File: doc/BRIEF.md
# Particle Regularization Jitter Unit

This block performs the regularization step of a particle filter, one particle at a time. A particle's state vector is written into an internal buffer beforehand. A pulse from the resampling stage then starts processing. The unit adds an approximately Gaussian perturbation to each of the first sixteen state words. Each perturbation is scaled by a shared bandwidth gain and by a per-word deviation factor.

After the perturbation, the three attitude words (roll, pitch, yaw) are folded back into the range [-pi, +pi]. A lookup table of sine values then turns the folded angles into a unit quaternion. The unit streams seventeen result words, one per clock: the thirteen jittered kinematic words first, then the four quaternion components.

All values are signed Q16.16. In this format pi is the integer 205887 and 2*pi is 411774.

Top module: `pj_jitter`

## Requirements
- R1: After reset, out_valid and done are low, every state and factor buffer entry reads as zero, and the noise generator holds the seed 32'h1ACE_B00C.
- R2: A reg_start pulse is accepted only while the unit is idle. A pulse that arrives during processing changes neither the output words nor their timing, and it does not start a second particle.
- R3: The noise generator is a right-shifting Galois LFSR. Each step computes next = (s >> 1) ^ (s[0] ? 32'h8020_0003 : 0). For each word w from 0 to 15, in order, four samples s[31:16] are summed, and the LFSR steps after each sample. The sum gives g = sum - 131070. The perturbation is (g * hopt * fac[w]) >>> 24, with hopt and fac taken as unsigned. The jittered word is the input word plus the perturbation, modulo 2^32.
- R4: Output words 0 to 12 equal jittered words 0 to 12 exactly.
- R5: Jittered words 13, 14 and 15 are angles (roll, pitch, yaw). Each is reduced by subtracting 411774 while it is above 205887 and adding 411774 while it is below -205887. One correction happens per clock, so both +pi and -pi are left unchanged.
- R6: Output words 13 to 16 are w, x, y, z. With c and s taken at half of each folded angle: w = cr*cp*cy + sr*sp*sy, x = sr*cp*cy - cr*sp*sy, y = cr*sp*cy + sr*cp*sy, z = cr*cp*sy - sr*sp*cy. Each component is within 0.03 of the exact value.
- R7: The sine table is indexed by round(|half angle| * 512 / pi), over 0 to 256 steps of one quadrant. Cosine reads the mirrored index and negative angles negate the sine, so zero angles give exactly (65536, 0, 0, 0).
- R8: Result words appear on 17 consecutive cycles with out_valid high and out_idx counting 0 to 16. done is high only together with index 16, and out_valid falls on the next cycle.
- R9: done is high during the cycle after the (101 + C)-th rising edge that follows the edge sampling reg_start, where C is the total number of angle corrections.
- R10: Writes to state slot 16 are ignored, and no output depends on them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| st_we | input | 1 | State buffer write strobe |
| st_addr | input | 5 | State word index |
| st_data | input | 32 | State word, Q16.16 |
| fac_we | input | 1 | Deviation factor write strobe |
| fac_addr | input | 5 | Deviation factor index (0 to 15) |
| fac_data | input | 16 | Deviation factor, unsigned |
| hopt | input | 16 | Bandwidth gain, unsigned, held during a particle |
| reg_start | input | 1 | Start pulse from the resampler |
| out_valid | output | 1 | Result word valid |
| out_idx | output | 5 | Result word index |
| out_data | output | 32 | Result word, Q16.16 |
| done | output | 1 | Marks the last result word of a particle |

## Verification
The result stream is due a fixed number of edges after the start is sampled: 80 edges of noise, one edge per angle plus one per correction, two edges of trigonometry, and then one word per edge. The bench counts falling edges from the sampling edge and predicts the exact count at which done appears, as 102 + C under that numbering. Each word is sampled at a falling edge and matched against its expected index. A start pulse injected mid-run must leave both the count and the words unchanged. After done, the next cycles are checked for silence.

// File: rtl/pj_pkg.sv
package pj_pkg;
   localparam int                 DATA_W  = 32;
   localparam logic signed [31:0] PI_FX   = 32'sd205887;
   localparam logic signed [31:0] TPI_FX  = 32'sd411774;
   localparam int                 TRIG_W  = 18;
   localparam int                 LUT_PTS = 256;
   localparam int                 IDX_W   = $clog2(LUT_PTS) + 1;
   // 2^24 * LUT_PTS / PI_FX, rounded down
   localparam int                 IDX_K   = 20860;

   typedef enum logic [2:0] {S_IDLE, S_NOISE, S_WRAP, S_TRIG, S_QUAT, S_OUT} pj_state_e;

   typedef struct packed {
      logic signed [TRIG_W-1:0] s;
      logic signed [TRIG_W-1:0] c;
   } pj_sc_t;

   function automatic int sin_q15(int k);
      real x;
      x = real'(k) * 3.141592653589793 / real'(2 * LUT_PTS);
      return $rtoi(32768.0 * $sin(x) + 0.5);
   endfunction
endpackage

// File: rtl/pj_gauss.sv
module pj_gauss #(
   parameter int          SAMPLES = 4,
   parameter int          G_W     = 20,
   parameter logic [31:0] SEED    = 32'h1ACE_B00C,
   parameter logic [31:0] MASK    = 32'h8020_0003
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  step,
   input  logic                  clr,
   output logic signed [G_W-1:0] g,
   output logic [31:0]           lfsr_q
);
   localparam int MEAN = SAMPLES * 65535 / 2;

   logic [G_W-1:0] acc;
   logic [31:0]    lfsr_n;

   assign lfsr_n = {1'b0, lfsr_q[31:1]} ^ (lfsr_q[0] ? MASK : 32'h0);
   assign g      = $signed(acc) - $signed(G_W'(MEAN));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lfsr_q <= SEED;
         acc    <= '0;
      end else if (step) begin
         acc    <= acc + G_W'(lfsr_q[31:16]);
         lfsr_q <= lfsr_n;
      end else if (clr) begin
         acc    <= '0;
      end
   end
endmodule

// File: rtl/pj_sincos.sv
module pj_sincos
   import pj_pkg::*;
(
   input  logic signed [31:0] ang,
   output pj_sc_t             sc
);
   logic [16:0]      tbl [0:LUT_PTS];
   logic [31:0]      mag;
   logic [23:0]      ipos;
   logic [IDX_W-1:0] idx;
   logic [16:0]      sm;
   logic [16:0]      cm;

   for (genvar k = 0; k <= LUT_PTS; k++) begin : g_tbl
      assign tbl[k] = 17'(sin_q15(k));
   end

   always_comb begin
      mag  = ang[31] ? 32'(-ang) : 32'(ang);
      ipos = 24'((48'(mag) * 48'(IDX_K) + 48'(1 << 23)) >> 24);
      idx  = (ipos > 24'(LUT_PTS)) ? IDX_W'(LUT_PTS) : ipos[IDX_W-1:0];
      sm   = tbl[idx];
      cm   = tbl[IDX_W'(LUT_PTS) - idx];
      sc.s = ang[31] ? -$signed({1'b0, sm}) : $signed({1'b0, sm});
      sc.c = $signed({1'b0, cm});
   end
endmodule

// File: rtl/pj_quat.sv
module pj_quat
   import pj_pkg::*;
(
   input  pj_sc_t          r,
   input  pj_sc_t          p,
   input  pj_sc_t          y,
   output logic [3:0][31:0] q
);
   localparam int TP_W  = 3 * TRIG_W;
   localparam int SHIFT = 45 - 16;

   function automatic logic signed [TP_W-1:0] tp(input logic signed [TRIG_W-1:0] a,
                                                 input logic signed [TRIG_W-1:0] b,
                                                 input logic signed [TRIG_W-1:0] c);
      return TP_W'(a) * TP_W'(b) * TP_W'(c);
   endfunction

   always_comb begin
      q[0] = 32'((tp(r.c, p.c, y.c) + tp(r.s, p.s, y.s)) >>> SHIFT);
      q[1] = 32'((tp(r.s, p.c, y.c) - tp(r.c, p.s, y.s)) >>> SHIFT);
      q[2] = 32'((tp(r.c, p.s, y.c) + tp(r.s, p.c, y.s)) >>> SHIFT);
      q[3] = 32'((tp(r.c, p.c, y.s) - tp(r.s, p.s, y.c)) >>> SHIFT);
   end
endmodule

// File: rtl/pj_jitter.sv
module pj_jitter
   import pj_pkg::*;
#(
   parameter int          N_PLAIN     = 13,
   parameter int          SAMPLES     = 4,
   parameter int          HOPT_W      = 16,
   parameter int          FAC_W       = 16,
   parameter int          NOISE_SHIFT = 24,
   parameter logic [31:0] LFSR_SEED   = 32'h1ACE_B00C,
   parameter logic [31:0] LFSR_MASK   = 32'h8020_0003,
   localparam int         N_JIT       = N_PLAIN + 3,
   localparam int         N_WORDS     = N_PLAIN + 4,
   localparam int         AW          = $clog2(N_WORDS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              st_we,
   input  logic [AW-1:0]     st_addr,
   input  logic [DATA_W-1:0] st_data,
   input  logic              fac_we,
   input  logic [AW-1:0]     fac_addr,
   input  logic [FAC_W-1:0]  fac_data,
   input  logic [HOPT_W-1:0] hopt,
   input  logic              reg_start,
   output logic              out_valid,
   output logic [AW-1:0]     out_idx,
   output logic [DATA_W-1:0] out_data,
   output logic              done
);
   localparam int G_W  = 16 + $clog2(SAMPLES) + 2;
   localparam int P_W  = G_W + HOPT_W + FAC_W + 2;
   localparam int CW   = $clog2(SAMPLES + 1);
   localparam int ANG0 = N_PLAIN;

   if (SAMPLES < 2 || SAMPLES % 2 != 0) begin : g_chk_samples
      $error("SAMPLES must be even and at least 2");
   end
   if (NOISE_SHIFT >= P_W) begin : g_chk_shift
      $error("NOISE_SHIFT exceeds product width");
   end
   if (N_PLAIN < 1) begin : g_chk_plain
      $error("N_PLAIN must be positive");
   end

   pj_state_e                state;
   logic [CW-1:0]            cnt;
   logic [AW-1:0]            widx;
   logic [1:0]               wj;
   logic [AW-1:0]            oidx;
   logic signed [DATA_W-1:0] in_buf  [N_WORDS];
   logic [FAC_W-1:0]         fac_buf [N_WORDS];
   logic signed [DATA_W-1:0] work    [N_WORDS];
   pj_sc_t                   sc_c [3];
   pj_sc_t                   sc_q [3];
   logic [3:0][31:0]         q_c;
   logic [3:0][31:0]         q_q;
   logic signed [G_W-1:0]    g;
   logic [31:0]              lfsr_q;
   logic signed [P_W-1:0]    prod;
   logic [DATA_W-1:0]        noise;
   logic signed [DATA_W-1:0] cur_ang;
   logic                     g_step;
   logic                     g_clr;

   assign g_step = (state == S_NOISE) && (cnt != CW'(SAMPLES));
   assign g_clr  = (state == S_NOISE) && (cnt == CW'(SAMPLES));

   pj_gauss #(.SAMPLES(SAMPLES), .G_W(G_W), .SEED(LFSR_SEED), .MASK(LFSR_MASK)) u_gauss (
      .clk(clk), .rst_n(rst_n), .step(g_step), .clr(g_clr), .g(g), .lfsr_q(lfsr_q)
   );

   for (genvar k = 0; k < 3; k++) begin : g_trig
      pj_sincos u_sc (.ang(work[ANG0+k]), .sc(sc_c[k]));
   end

   pj_quat u_quat (.r(sc_q[0]), .p(sc_q[1]), .y(sc_q[2]), .q(q_c));

   always_comb begin
      prod    = P_W'(g) * P_W'($signed({1'b0, hopt})) * P_W'($signed({1'b0, fac_buf[widx]}));
      noise   = DATA_W'(prod >>> NOISE_SHIFT);
      cur_ang = work[AW'(ANG0) + AW'(wj)];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state <= S_IDLE;
         cnt   <= '0;
         widx  <= '0;
         wj    <= '0;
         oidx  <= '0;
         for (int i = 0; i < N_WORDS; i++) begin
            in_buf[i]  <= '0;
            fac_buf[i] <= '0;
            work[i]    <= '0;
         end
         for (int k = 0; k < 3; k++) sc_q[k] <= '0;
         q_q <= '0;
      end else begin
         if (st_we && st_addr < AW'(N_JIT)) in_buf[st_addr] <= st_data;
         if (fac_we && fac_addr < AW'(N_JIT)) fac_buf[fac_addr] <= fac_data;
         unique case (state)
            S_IDLE: if (reg_start) begin
               state <= S_NOISE;
               cnt   <= '0;
               widx  <= '0;
            end
            S_NOISE: if (cnt == CW'(SAMPLES)) begin
               work[widx] <= in_buf[widx] + noise;
               cnt        <= '0;
               if (widx == AW'(N_JIT - 1)) begin
                  state <= S_WRAP;
                  wj    <= '0;
               end else begin
                  widx <= widx + 1'b1;
               end
            end else begin
               cnt <= cnt + 1'b1;
            end
            S_WRAP: begin
               if (cur_ang > PI_FX)       work[AW'(ANG0) + AW'(wj)] <= cur_ang - TPI_FX;
               else if (cur_ang < -PI_FX) work[AW'(ANG0) + AW'(wj)] <= cur_ang + TPI_FX;
               else if (wj == 2'd2)       state <= S_TRIG;
               else                       wj <= wj + 1'b1;
            end
            S_TRIG: begin
               for (int k = 0; k < 3; k++) sc_q[k] <= sc_c[k];
               state <= S_QUAT;
            end
            S_QUAT: begin
               q_q   <= q_c;
               oidx  <= '0;
               state <= S_OUT;
            end
            S_OUT: begin
               if (oidx == AW'(N_WORDS - 1)) state <= S_IDLE;
               else                          oidx  <= oidx + 1'b1;
            end
            default: state <= S_IDLE;
         endcase
      end
   end

   assign out_valid = (state == S_OUT);
   assign out_idx   = oidx;
   assign out_data  = (oidx < AW'(N_PLAIN)) ? work[oidx] : q_q[2'(oidx - AW'(N_PLAIN))];
   assign done      = out_valid && (oidx == AW'(N_WORDS - 1));
endmodule

// File: rtl/pj_jitter_chk.sv
module pj_jitter_chk
   import pj_pkg::*;
#(
   parameter int AW   = 5,
   parameter int LAST = 16,
   parameter int QIDX = 13
) (
   input logic               clk,
   input logic               rst_n,
   input logic               out_valid,
   input logic [AW-1:0]      out_idx,
   input logic signed [31:0] out_data,
   input logic               done,
   input pj_state_e          st,
   input logic signed [31:0] ang_r,
   input logic signed [31:0] ang_p,
   input logic signed [31:0] ang_y,
   input logic [31:0]        lfsr
);
   // R8: done only with the last word
   a_r8_done_last: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (out_valid && out_idx == AW'(LAST)));

   // R8: indices advance by one while streaming
   a_r8_idx_step: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_idx != AW'(LAST)) |=> (out_valid && out_idx == $past(out_idx) + 1'b1));

   // R8: stream starts at index zero
   a_r8_first_zero: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(out_valid) |-> (out_idx == '0));

   // R8 / R2: the stream stops after done
   a_r8_quiet_after: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !out_valid);

   // R5: folded angles lie in range before the table lookup
   a_r5_angles_folded: assert property (@(posedge clk) disable iff (!rst_n)
      (st == S_TRIG) |-> (ang_r <= PI_FX && ang_r >= -PI_FX &&
                          ang_p <= PI_FX && ang_p >= -PI_FX &&
                          ang_y <= PI_FX && ang_y >= -PI_FX));

   // R6: quaternion components stay bounded
   a_r6_quat_bounded: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_idx >= AW'(QIDX)) |-> (out_data <= 32'sd131072 && out_data >= -32'sd131072));

   // R3: the noise register never locks up at zero
   a_r3_lfsr_alive: assert property (@(posedge clk) disable iff (!rst_n)
      lfsr != 32'h0);
endmodule

bind pj_jitter pj_jitter_chk #(.AW(AW), .LAST(N_WORDS - 1), .QIDX(N_PLAIN)) u_chk (
   .clk(clk), .rst_n(rst_n), .out_valid(out_valid), .out_idx(out_idx), .out_data(out_data),
   .done(done), .st(state), .ang_r(work[N_PLAIN]), .ang_p(work[N_PLAIN+1]),
   .ang_y(work[N_PLAIN+2]), .lfsr(lfsr_q)
);

// File: tb/pj_jitter_test.sv
module pj_jitter_test;
   localparam int          PI_I  = 205887;
   localparam int          TPI_I = 411774;
   localparam logic [31:0] SEED  = 32'h1ACE_B00C;
   localparam logic [31:0] MASK  = 32'h8020_0003;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        st_we = 1'b0;
   logic [4:0]  st_addr = '0;
   logic [31:0] st_data = '0;
   logic        fac_we = 1'b0;
   logic [4:0]  fac_addr = '0;
   logic [15:0] fac_data = '0;
   logic [15:0] hopt = '0;
   logic        reg_start = 1'b0;
   logic        out_valid;
   logic [4:0]  out_idx;
   logic [31:0] out_data;
   logic        done;

   int n_chk = 0;
   int n_fail = 0;
   int cyc = 0;
   int st_v [17];
   int fc_v [16];
   int ex_w [13];
   int ex_q [4];
   int ex_corr;
   logic [31:0] m_lfsr = SEED;

   always #2 clk = ~clk;

   pj_jitter uut (
      .clk(clk), .rst_n(rst_n), .st_we(st_we), .st_addr(st_addr), .st_data(st_data),
      .fac_we(fac_we), .fac_addr(fac_addr), .fac_data(fac_data), .hopt(hopt),
      .reg_start(reg_start), .out_valid(out_valid), .out_idx(out_idx),
      .out_data(out_data), .done(done)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic logic [31:0] lfsr_step(input logic [31:0] s);
      return {1'b0, s[31:1]} ^ (s[0] ? MASK : 32'h0);
   endfunction

   task automatic model();
      int jw [16];
      real h [3];
      real cr, sr, cp, sp, cy, sy;
      ex_corr = 0;
      for (int w = 0; w < 16; w++) begin
         longint acc = 0;
         longint p;
         for (int k = 0; k < 4; k++) begin
            acc    += longint'(m_lfsr[31:16]);
            m_lfsr  = lfsr_step(m_lfsr);
         end
         p     = (acc - 131070) * longint'(hopt) * longint'(fc_v[w]);
         jw[w] = st_v[w] + int'(p >>> 24);
      end
      for (int w = 0; w < 13; w++) ex_w[w] = jw[w];
      for (int k = 0; k < 3; k++) begin
         int a = jw[13+k];
         while (a > PI_I)  begin a -= TPI_I; ex_corr++; end
         while (a < -PI_I) begin a += TPI_I; ex_corr++; end
         h[k] = real'(a) / 65536.0 / 2.0;
      end
      cr = $cos(h[0]); sr = $sin(h[0]);
      cp = $cos(h[1]); sp = $sin(h[1]);
      cy = $cos(h[2]); sy = $sin(h[2]);
      ex_q[0] = $rtoi((cr*cp*cy + sr*sp*sy) * 65536.0);
      ex_q[1] = $rtoi((sr*cp*cy - cr*sp*sy) * 65536.0);
      ex_q[2] = $rtoi((cr*sp*cy + sr*cp*sy) * 65536.0);
      ex_q[3] = $rtoi((cr*cp*sy - sr*sp*cy) * 65536.0);
   endtask

   task automatic load(input bit do_load);
      if (!do_load) return;
      for (int w = 0; w < 17; w++) begin
         @(negedge clk);
         st_we = 1'b1; st_addr = 5'(w); st_data = st_v[w];
         fac_we = (w < 16); fac_addr = 5'(w); fac_data = (w < 16) ? 16'(fc_v[w]) : 16'h0;
      end
      @(negedge clk);
      st_we = 1'b0; fac_we = 1'b0;
   endtask

   // tol < 0: exact quaternion check
   task automatic run(input string tag, input bit do_load, input bit poke, input int tol);
      int n = 1;
      int k = 0;
      bit seen = 1'b0;
      load(do_load);
      model();
      @(negedge clk);
      reg_start = 1'b1;
      @(posedge clk);
      @(negedge clk);
      reg_start = 1'b0;
      while (!seen && n < 20000) begin
         if (out_valid) begin
            check(out_idx == 5'(k), "R8", {tag, " index order"}, out_idx, k);
            if (k < 13)
               check(out_data == ex_w[k], "R4", {tag, " jittered word (R3 R10)"}, $signed(out_data), ex_w[k]);
            else if (tol < 0)
               check(out_data == ex_q[k-13], "R7", {tag, " exact quaternion"}, $signed(out_data), ex_q[k-13]);
            else begin
               longint d = longint'($signed(out_data)) - longint'(ex_q[k-13]);
               check(d <= tol && d >= -tol, "R6", {tag, " quaternion component"}, $signed(out_data), ex_q[k-13]);
            end
            check(done == (k == 16), "R8", {tag, " done placement"}, done, k == 16);
            if (done) begin
               seen = 1'b1;
               check(n == 102 + ex_corr, "R9", {tag, " done latency"}, n, 102 + ex_corr);
            end
            k++;
         end
         reg_start = (poke && n == 40);
         if (!seen) begin
            @(negedge clk);
            n++;
         end
      end
      reg_start = 1'b0;
      check(k == 17, "R8", {tag, " word count"}, k, 17);
      for (int i = 0; i < 4; i++) begin
         @(negedge clk);
         check(!out_valid, "R2", {tag, " no extra run after done"}, out_valid, 0);
      end
   endtask

   initial begin
      while (cyc < 150000) begin
         @(posedge clk);
         cyc++;
      end
      n_fail++;
      $display("FAIL watchdog: actual %0d expected below %0d cycles", cyc, 150000);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      void'($urandom(32'd2024));
      repeat (3) @(negedge clk);
      check(out_valid == 1'b0, "R1", "out_valid after reset", out_valid, 0);
      check(done == 1'b0, "R1", "done after reset", done, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(out_valid == 1'b0, "R1", "idle after reset release", out_valid, 0);

      // R1 R7: empty buffers, zero gain -> zero words, identity quaternion
      for (int w = 0; w < 17; w++) st_v[w] = 0;
      for (int w = 0; w < 16; w++) fc_v[w] = 0;
      hopt = 16'd0;
      run("R1 reset buffers", 1'b0, 1'b0, -1);

      // R6 R10: edge angles +pi, -pi, 0, junk in slot 16
      for (int w = 0; w < 13; w++) st_v[w] = w * 1000 - 5000;
      st_v[13] = PI_I; st_v[14] = -PI_I; st_v[15] = 0; st_v[16] = 32'hDEAD_BEEF;
      run("R6 R10 edge angles", 1'b1, 1'b0, 2000);

      // R5 R9: angles needing several corrections
      st_v[13] = 600000; st_v[14] = -700000; st_v[15] = 7 * PI_I;
      run("R5 R9 folding", 1'b1, 1'b0, 2000);

      // R2: start pulse injected while busy
      st_v[13] = 100000; st_v[14] = -50000; st_v[15] = 30000;
      run("R2 busy restart", 1'b1, 1'b1, 2000);

      // R3: large gain on plain words
      hopt = 16'hFFFF;
      for (int w = 0; w < 13; w++) fc_v[w] = 16'hFFFF;
      for (int w = 13; w < 16; w++) fc_v[w] = 0;
      run("R3 large noise", 1'b1, 1'b0, 2000);

      // R3 R4 R5 R6 R10: random particles
      for (int t = 0; t < 20; t++) begin
         hopt = 16'($urandom_range(0, 4095));
         for (int w = 0; w < 16; w++) fc_v[w] = int'($urandom_range(0, 1023));
         for (int w = 0; w < 13; w++) st_v[w] = int'($urandom);
         for (int w = 13; w < 16; w++) st_v[w] = int'($urandom_range(0, 8 * PI_I)) - 4 * PI_I;
         st_v[16] = int'($urandom);
         run("R3 random particle", 1'b1, (t % 5 == 2), 2000);
      end

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule